// File: doc/BRIEF.md
# Programmable Timeout and Retry Timer

This block is the time-out engine of a serial protocol controller. It counts ticks from one of two enables that are already synchronised to the system clock. The first is the effective transmit clock. The second is a frame-sync strobe, which can only be chosen when the controller runs in the clock mode that supplies frame sync. The time-out period is a 16-bit value V, and each period lasts V+1 ticks.

The block has two behaviours, selected by a mode input. In software mode, command strobes start and stop the timer. Every expiry gives a one-cycle interrupt pulse. A 3-bit count field sets how many automatic restarts follow, and the all-ones code makes the timer periodic. In protocol mode, a pulse saying that an information frame was sent arms the timer. Each expiry with retries left requests one poll supervisory frame. When the retry budget runs out, the block raises a retry-exhausted pulse and stops. An acknowledge pulse ends the sequence at any point. The period and the count field are sampled whenever the timer loads, so changes made during a run take effect at the next reload.

Top module: `tmo_retry_timer`

## Requirements
- R1: The tick is `fsync_tick` when both `src_fsync` and `fsync_clk_mode` are 1. Otherwise it is `txclk_tick`, and the other enable has no effect.
- R2: After a start, the expiry happens on the (V+1)th tick, where V is `period`. V=0 expires on the first tick. A tick in the same cycle as a start is not counted.
- R3: In software mode (`proto_mode`=0), `cmd_start` starts the timer. A start while running reloads the period and clears the restart count. `cmd_stop` stops the timer and wins over a start in the same cycle.
- R4: In software mode, each expiry gives `tmr_irq` high for exactly one cycle, in the cycle after the expiring tick. `tmr_irq` never fires in protocol mode.
- R5: With `retry_cnt` N in 0..6, a software-mode run gives N automatic restarts, which is N+1 interrupts, and then `running` drops.
- R6: With `retry_cnt`=7, the timer restarts forever and gives one interrupt every V+1 ticks.
- R7: In protocol mode, `iframe_sent` arms the timer. `link_ack` stops it and clears the retry count, and it wins over `iframe_sent` in the same cycle.
- R8: In protocol mode, an expiry with retries left gives a one-cycle `poll_req` and reloads the timer. N in 0..6 allows N polls, and 7 allows unlimited polls.
- R9: In protocol mode, an expiry once N polls have been issued gives a one-cycle `retry_exhausted`, with no `poll_req`, and the timer stops.
- R10: `running` is high from the cycle after a start until the cycle after the final expiry or a stop.
- R11: `period` and `retry_cnt` are sampled at each load, so a change during a run applies from the next reload.
- R12: After reset, `running`, `tmr_irq`, `poll_req` and `retry_exhausted` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_fsync | input | 1 | Tick source select (1 = frame sync) |
| fsync_clk_mode | input | 1 | High when the clock mode supplies frame sync |
| proto_mode | input | 1 | 0 = software control, 1 = protocol retry |
| retry_cnt | input | 3 | Restart or retry limit (7 = unlimited) |
| period | input | 16 | Time-out value V, giving V+1 ticks |
| txclk_tick | input | 1 | Transmit-clock enable |
| fsync_tick | input | 1 | Frame-sync enable |
| cmd_start | input | 1 | Software start strobe |
| cmd_stop | input | 1 | Software stop strobe |
| iframe_sent | input | 1 | Information frame sent (arms in protocol mode) |
| link_ack | input | 1 | Acknowledge received (stops in protocol mode) |
| running | output | 1 | Timer counting |
| tmr_irq | output | 1 | Expiry interrupt pulse |
| poll_req | output | 1 | Poll frame request pulse |
| retry_exhausted | output | 1 | Retry budget used pulse |

## Verification
The assertions assume that both tick inputs are single-cycle enables already in the clock domain. They also assume that the mode and configuration inputs change only between clock edges. The interrupt-mode check relies on `proto_mode` being read in the cycle of the expiring tick. The bench changes configuration only at falling edges, and does so rarely and at random. Its reference model reads every input live at each rising edge, which matches what the assertions assume.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int RC_W = 3;
  localparam logic [RC_W-1:0] RC_FOREVER = '1;

  // retries remain when the limit is unlimited or not yet reached
  function automatic logic more_left(input logic [RC_W-1:0] used,
                                     input logic [RC_W-1:0] limit);
    return (limit == RC_FOREVER) || (used < limit);
  endfunction

  // saturating increment of the restart tally
  function automatic logic [RC_W-1:0] bump_sat(input logic [RC_W-1:0] v);
    return (v == RC_FOREVER) ? v : v + 1'b1;
  endfunction

  // the frame-sync source applies only in the frame-sync clock mode
  function automatic logic pick_tick(input logic sel, input logic fs_mode,
                                     input logic tx, input logic fs);
    return (sel && fs_mode) ? fs : tx;
  endfunction
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_fsync,
  input  logic fsync_clk_mode,
  input  logic txclk_tick,
  input  logic fsync_tick,
  output logic tick
);
  assign tick = pick_tick(src_fsync, fsync_clk_mode, txclk_tick, fsync_tick);

  // R1: a tick always comes from one of the two enables
  a_r1_tick_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (txclk_tick || fsync_tick));
  // R1: outside frame-sync clock mode the frame-sync enable is ignored
  a_r1_fsync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync_clk_mode && !txclk_tick) |-> !tick);
endmodule

// File: rtl/tmr_period_cnt.sv
module tmr_period_cnt #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick_en,
  input  logic [VAL_W-1:0] period,
  output logic             expire
);
  logic [VAL_W-1:0] remain;

  assign expire = tick_en && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         remain <= '0;
    else if (load)                      remain <= period;
    else if (tick_en && remain != '0)   remain <= remain - 1'b1;
  end

  // R2: each counted tick takes one step off the remaining time
  a_r2_tick_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load && remain != '0) |=> remain == $past(remain) - 1'b1);
  // R2: the count holds steady between ticks
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load) |=> $stable(remain));
endmodule

// File: rtl/tmr_retry_ctrl.sv
module tmr_retry_ctrl
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic            expire,
  input  logic            proto_mode,
  input  logic [RC_W-1:0] retry_cnt,
  output logic            reload,
  output logic            running,
  output logic            tmr_irq,
  output logic            poll_req,
  output logic            retry_exhausted
);
  logic [RC_W-1:0] used_q;
  logic [RC_W-1:0] limit_q;
  logic            left;

  assign left   = more_left(used_q, limit_q);
  assign reload = expire && left && !stop_evt && !start_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; used_q <= '0; limit_q <= '0;
      tmr_irq <= 1'b0; poll_req <= 1'b0; retry_exhausted <= 1'b0;
    end else begin
      tmr_irq <= 1'b0; poll_req <= 1'b0; retry_exhausted <= 1'b0;
      if (stop_evt) begin
        running <= 1'b0;
        used_q  <= '0;
      end else if (start_evt) begin
        running <= 1'b1;
        used_q  <= '0;
        limit_q <= retry_cnt;
      end else if (expire) begin
        if (!proto_mode) tmr_irq <= 1'b1;
        if (left) begin
          if (proto_mode) poll_req <= 1'b1;
          used_q  <= bump_sat(used_q);
          limit_q <= retry_cnt;
        end else begin
          running <= 1'b0;
          if (proto_mode) retry_exhausted <= 1'b1;
        end
      end
    end
  end

  // R3 / R7: a stop always leaves the timer idle
  a_r3_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !running);
  // R4: interrupts only in software mode
  a_r4_irq_software_only: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && proto_mode) |=> !tmr_irq);
  // R9: exhaustion ends the run
  a_r9_exhaust_stops: assert property (@(posedge clk) disable iff (!rst_n)
    retry_exhausted |-> !running);
  // R8 / R9: a poll and an exhaustion never coincide
  a_r8_poll_excl_exhaust: assert property (@(posedge clk) disable iff (!rst_n)
    !(poll_req && retry_exhausted));
  // R10: pulses only follow a cycle in which the timer was running
  a_r10_pulse_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_irq || poll_req || retry_exhausted) |-> $past(running));
endmodule

// File: rtl/tmo_retry_timer.sv
module tmo_retry_timer
  import tmr_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_fsync,
  input  logic             fsync_clk_mode,
  input  logic             proto_mode,
  input  logic [RC_W-1:0]  retry_cnt,
  input  logic [VAL_W-1:0] period,
  input  logic             txclk_tick,
  input  logic             fsync_tick,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             iframe_sent,
  input  logic             link_ack,
  output logic             running,
  output logic             tmr_irq,
  output logic             poll_req,
  output logic             retry_exhausted
);
  logic tick, tick_en, start_evt, stop_evt, expire, reload, load;

  // command decode: the stop-type event always wins
  assign stop_evt  = proto_mode ? link_ack : cmd_stop;
  assign start_evt = !stop_evt && (proto_mode ? iframe_sent : cmd_start);
  assign tick_en   = running && tick && !start_evt && !stop_evt;
  assign load      = start_evt || reload;

  tmr_tick_sel u_tick (
    .clk(clk), .rst_n(rst_n), .src_fsync(src_fsync),
    .fsync_clk_mode(fsync_clk_mode), .txclk_tick(txclk_tick),
    .fsync_tick(fsync_tick), .tick(tick)
  );

  tmr_period_cnt #(.VAL_W(VAL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .tick_en(tick_en),
    .period(period), .expire(expire)
  );

  tmr_retry_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .expire(expire), .proto_mode(proto_mode), .retry_cnt(retry_cnt),
    .reload(reload), .running(running), .tmr_irq(tmr_irq),
    .poll_req(poll_req), .retry_exhausted(retry_exhausted)
  );

  // R12: no pulse while held idle
  a_r12_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(running)) |-> !(tmr_irq || poll_req || retry_exhausted));
  // R10: a start always leaves the timer running
  a_r10_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> running);
endmodule

// File: tb/tmo_retry_timer_test.sv
module tmo_retry_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic src_fsync = 0, fsync_clk_mode = 0, proto_mode = 0;
  logic [2:0] retry_cnt = 0;
  logic [15:0] period = 0;
  logic txclk_tick = 0, fsync_tick = 0, cmd_start = 0, cmd_stop = 0;
  logic iframe_sent = 0, link_ack = 0;
  logic running, tmr_irq, poll_req, retry_exhausted;

  int checks = 0, failures = 0;
  int n_irq = 0, n_poll = 0, n_exh = 0;
  // reference model state
  logic m_run = 0, m_irq = 0, m_poll = 0, m_exh = 0;
  int m_el = 0, m_per = 0, m_lim = 0, m_done = 0;

  always #2.5 clk = ~clk;

  tmo_retry_timer uut (
    .clk(clk), .rst_n(rst_n), .src_fsync(src_fsync),
    .fsync_clk_mode(fsync_clk_mode), .proto_mode(proto_mode),
    .retry_cnt(retry_cnt), .period(period), .txclk_tick(txclk_tick),
    .fsync_tick(fsync_tick), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .iframe_sent(iframe_sent), .link_ack(link_ack), .running(running),
    .tmr_irq(tmr_irq), .poll_req(poll_req), .retry_exhausted(retry_exhausted)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic retries_left(input int done, input int lim);
    return (lim == 7) || (done < lim);
  endfunction

  // elapsed-tick reference, counting upward toward the period
  task automatic model(input logic st, sp, sn, ak, tx, fs);
    logic tk, stop_e, start_e;
    m_irq = 0; m_poll = 0; m_exh = 0;
    tk = (src_fsync && fsync_clk_mode) ? fs : tx;
    stop_e = proto_mode ? ak : sp;
    start_e = !stop_e && (proto_mode ? sn : st);
    if (stop_e) begin m_run = 0; m_done = 0; end
    else if (start_e) begin
      m_run = 1; m_el = 0; m_per = int'(period); m_lim = int'(retry_cnt); m_done = 0;
    end else if (m_run && tk) begin
      if (m_el == m_per) begin
        if (!proto_mode) m_irq = 1;
        if (retries_left(m_done, m_lim)) begin
          if (proto_mode) m_poll = 1;
          m_el = 0; m_per = int'(period); m_lim = int'(retry_cnt);
          if (m_done < 7) m_done++;
        end else begin
          m_run = 0;
          if (proto_mode) m_exh = 1;
        end
      end else m_el++;
    end
  endtask

  task automatic step(input logic st, sp, sn, ak, tx, fs);
    cmd_start = st; cmd_stop = sp; iframe_sent = sn; link_ack = ak;
    txclk_tick = tx; fsync_tick = fs;
    @(posedge clk);
    model(st, sp, sn, ak, tx, fs);
    @(negedge clk);
    n_irq += int'(tmr_irq); n_poll += int'(poll_req); n_exh += int'(retry_exhausted);
    check(tmr_irq == m_irq, "R4 irq vs model", int'(tmr_irq), int'(m_irq));
    check(poll_req == m_poll, "R8 poll vs model", int'(poll_req), int'(m_poll));
    check(retry_exhausted == m_exh, "R9 exhausted vs model", int'(retry_exhausted), int'(m_exh));
    check(running == m_run, "R10 running vs model", int'(running), int'(m_run));
  endtask

  task automatic clr();
    n_irq = 0; n_poll = 0; n_exh = 0;
  endtask

  task automatic idle();
    step(0, 1, 0, 1, 0, 0);
    clr();
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int first;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12: reset state
    check({running, tmr_irq, poll_req, retry_exhausted} == 4'b0, "R12 reset outputs",
          int'({running, tmr_irq, poll_req, retry_exhausted}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: period 3 expires on the fourth tick
    period = 3; retry_cnt = 0; idle();
    step(1, 0, 0, 0, 1, 0);
    first = 0;
    for (int i = 1; i <= 6; i++) begin
      step(0, 0, 0, 0, 1, 0);
      if (tmr_irq && first == 0) first = i;
    end
    check(first == 4, "R2 expiry tick index", first, 4);
    // R5: count 0 means a single interrupt, then stop
    check(n_irq == 1 && !running, "R5 count0 single irq", n_irq, 1);

    // R2: value 0 expires on first tick
    period = 0; idle();
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    check(tmr_irq == 1, "R2 zero period first tick", int'(tmr_irq), 1);

    // R1: frame-sync ignored outside its clock mode
    src_fsync = 1; fsync_clk_mode = 0; idle();
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1);
    check(n_irq == 0 && running, "R1 fsync ignored", n_irq, 0);
    step(0, 0, 0, 0, 1, 0);
    check(n_irq == 1, "R1 tx used when mode off", n_irq, 1);
    // R1: in frame-sync mode the transmit tick is ignored
    fsync_clk_mode = 1; idle();
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0);
    check(n_irq == 0, "R1 tx ignored with fsync", n_irq, 0);
    step(0, 0, 0, 0, 0, 1);
    check(n_irq == 1, "R1 fsync ticks", n_irq, 1);
    src_fsync = 0; fsync_clk_mode = 0;

    // R5: two restarts give three interrupts
    period = 0; retry_cnt = 2; idle();
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, 0);
    check(n_irq == 3 && !running, "R5 restarts", n_irq, 3);

    // R6: unlimited, periodic
    period = 1; retry_cnt = 7; idle();
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 0);
    check(n_irq == 10 && running, "R6 periodic irq", n_irq, 10);

    // R3: stop wins over start
    idle();
    step(1, 1, 0, 0, 0, 0);
    check(running == 0, "R3 stop wins", int'(running), 0);
    // R3: restart reloads the period
    period = 2; retry_cnt = 0;
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0);
    check(n_irq == 0, "R3 restart reloads", n_irq, 0);
    step(0, 0, 0, 0, 1, 0);
    check(n_irq == 1, "R3 expiry after reload", n_irq, 1);

    // R11: period change applies at the next reload
    period = 1; retry_cnt = 7; idle();
    step(1, 0, 0, 0, 0, 0);
    period = 5;
    step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0);
    check(n_irq == 1, "R11 old period kept", n_irq, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0);
    check(n_irq == 1, "R11 new period pending", n_irq, 1);
    step(0, 0, 0, 0, 1, 0);
    check(n_irq == 2, "R11 new period applied", n_irq, 2);

    // R8 / R9: protocol mode, three polls then exhausted
    proto_mode = 1; period = 0; retry_cnt = 3; idle();
    step(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, 0);
    check(n_poll == 3, "R8 poll count", n_poll, 3);
    check(n_exh == 1 && !running, "R9 exhausted once", n_exh, 1);
    check(n_irq == 0, "R4 no irq in protocol mode", n_irq, 0);
    // R9: zero budget exhausts on first expiry
    retry_cnt = 0; idle();
    step(0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 1, 0);
    check(n_exh == 1 && n_poll == 0, "R9 zero budget", n_exh, 1);
    // R7: acknowledge stops and later ticks do nothing
    retry_cnt = 3; idle();
    step(0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0);
    check(n_poll == 1 && n_exh == 0 && !running, "R7 ack stops", n_poll, 1);
    step(0, 0, 1, 1, 0, 0);
    check(running == 0, "R7 ack wins over arm", int'(running), 0);
    // R8: unlimited polls
    retry_cnt = 7; idle();
    step(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, 0);
    check(n_poll == 12 && n_exh == 0, "R8 unlimited polls", n_poll, 12);

    // random phase, checked against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(19) == 0) begin
        period = 16'($urandom_range(4)); retry_cnt = 3'($urandom_range(7));
        src_fsync = 1'($urandom_range(1)); fsync_clk_mode = 1'($urandom_range(1));
        proto_mode = 1'($urandom_range(1));
      end
      step($urandom_range(24) == 0, $urandom_range(59) == 0,
           $urandom_range(24) == 0, $urandom_range(59) == 0,
           $urandom_range(1) == 0, $urandom_range(2) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule